// File: doc/BRIEF.md
# Parallel Memory Write Sequencer

This block sits on the host side of an asynchronous byte-wide memory whose writes are self-timed. A client hands it one request at a time over a valid/ready handshake: an address, a direction and, for a write, a data byte. The block drives the memory's active-low chip-enable, output-enable and write-enable. It keeps every setup, pulse, hold and access interval at or above a count of system clocks, and each count is set by a parameter.

A read is a single access window. At the end of the window the block captures the data bus and answers the client. A write is not finished when the write strobe ends, because the memory then spends up to several milliseconds storing the byte internally. After a short busy-report delay the block waits for completion in one of two ways, chosen per request by `mode_poll`. In the first, it waits for the open-drain ready line to go high. In the second, it runs repeated read cycles and compares bit 7 of the returned byte with bit 7 of the written byte; while the store is pending, the memory returns that bit inverted. A timeout counter bounds the wait. If it expires, the block answers with an error flag and releases all strobes.

Top module: `pmem_wr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for T_READ clock cycles. It then captures `mem_din` into `rsp_rdata` and raises `rsp_valid` with `rsp_err`=0. Data present on `mem_din` before T_READ cycles of output-enable have passed is not captured.
- R3: Before `mem_we_n` falls, a write holds `mem_ce_n`=0, `mem_oe_n`=1, `mem_dout_en`=1 and the address and data on the bus for at least T_SETUP cycles.
- R4: `mem_we_n` stays low for at least T_PULSE cycles. During that time `mem_ce_n` is 0, `mem_oe_n` is 1, and `mem_addr` and `mem_dout` do not change.
- R5: After `mem_we_n` rises, `mem_ce_n` stays 0 and the data stays driven for at least T_HOLD cycles.
- R6: After the hold, every strobe is high for T_BUSY_DLY cycles before the block looks at `mem_ready` or starts a poll read. A ready line that is still high at that point is not taken as completion.
- R7: With `mode_poll`=0 captured at acceptance, a write is acknowledged (`rsp_valid`=1, `rsp_err`=0) only after `mem_ready` is sampled high following the busy delay.
- R8: With `mode_poll`=1, the block repeats T_READ-cycle read cycles at the write address. It acknowledges with `rsp_err`=0 on the first read whose `mem_din[7]` equals bit 7 of the written byte. Between two poll reads, `mem_oe_n` stays 1 for at least T_GAP cycles.
- R9: If a write has not completed within TIMEOUT_CYC cycles after the busy delay starts, the block raises `rsp_valid` with `rsp_err`=1 and returns to idle with all strobes high and `mem_dout_en`=0.
- R10: `req_ready` is 1 only in idle and stays 0 from acceptance until the acknowledge. `rsp_valid` lasts exactly one cycle, and `rsp_err` is 1 only together with `rsp_valid`.
- R11: `mem_dout_en` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_poll | input | 1 | Completion method for a write, captured with the request: 1 = bit-7 polling, 0 = ready line |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_err | output | 1 | Write completion timed out |
| rsp_rdata | output | DATA_W | Byte returned by a read |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_dout_en | output | 1 | Enable for the pad driver of `mem_dout` |
| mem_din | input | DATA_W | Data from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ready | input | 1 | Ready line, low while a store is in progress |

## Verification
The bench's memory model holds its ready line high for a few cycles after the write strobe. A sequencer that skips the busy delay therefore acknowledges too early, and the memory model still holds the old byte. The model returns valid read data only after T_READ cycles of output-enable, so a read or poll that samples one cycle early captures an inverted byte. Polling is exercised with bit 7 both set and clear. Poll reads are counted and their gaps measured, so a sequencer that holds output-enable low across polls, or that ends on the first poll, is reported. A stuck memory drives both timeout paths, and the bench checks the error flag, the minimum latency and the released strobes.

// File: rtl/pmem_seq_pkg.sv
// Shared types for the parallel memory sequencer.
// Assumes the strobes are active low and the data pad is enabled separately.
package pmem_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_BSY_DLY,
        ST_RB_WAIT,
        ST_POLL_RD,
        ST_POLL_GAP
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    // Map a sequencer state to the levels on the memory control pins.
    function automatic strobe_t strobe_for(seq_state_e s);
        strobe_t r;
        r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_RD_ACC, ST_POLL_RD: begin
                r.ce_n = 1'b0;
                r.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                r.ce_n  = 1'b0;
                r.drive = 1'b1;
            end
            ST_WR_PULSE: begin
                r.ce_n  = 1'b0;
                r.we_n  = 1'b0;
                r.drive = 1'b1;
            end
            default: r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return r;
    endfunction

    // States in which a write is waiting for the memory to finish storing.
    function automatic logic is_wait_state(seq_state_e s);
        return (s == ST_BSY_DLY) || (s == ST_RB_WAIT) ||
               (s == ST_POLL_RD) || (s == ST_POLL_GAP);
    endfunction

endpackage

// File: rtl/pmem_phase_timer.sv
// Down-counter that times one phase of a memory cycle.
// Loading N-1 on entry to a phase makes `expired` rise in the phase's N-th cycle.
// Assumes a load value of zero means a one-cycle phase.
module pmem_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The phase has run its full length.
    assign expired = (cnt == '0);
endmodule

// File: rtl/pmem_poll_timeout.sv
// Counts the cycles spent waiting for a self-timed write to complete.
// Cleared when a request is accepted; `fired` is high in the LIMIT-th wait cycle.
module pmem_poll_timeout #(
    parameter int LIMIT = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic fired
);
    localparam int TO_W = $clog2(LIMIT + 1);
    localparam logic [TO_W-1:0] LAST = TO_W'(LIMIT - 1);

    logic [TO_W-1:0] cnt;

    // Count wait cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run && (cnt != LAST))
            cnt <= cnt + 1'b1;
    end

    // Limit reached while still waiting.
    assign fired = run && (cnt == LAST);
endmodule

// File: rtl/pmem_req_latch.sv
// Holds the accepted request for the whole memory transaction, so the
// client's bus is free again once the request is accepted.
module pmem_req_latch #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              write_i,
    input  logic              poll_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              write_o,
    output logic              poll_o
);
    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            data_o  <= '0;
            write_o <= 1'b0;
            poll_o  <= 1'b0;
        end else if (capture) begin
            addr_o  <= addr_i;
            data_o  <= data_i;
            write_o <= write_i;
            poll_o  <= poll_i;
        end
    end
endmodule

// File: rtl/pmem_wr_seq.sv
// Host-side sequencer for an asynchronous byte-wide memory with self-timed writes.
// It runs read cycles and write cycles with programmable setup, pulse and hold
// lengths in clocks. After a write it waits for completion on the ready line or
// by polling bit DATA_W-1, under a timeout.
// Assumes: every timing parameter is at least 1; the ready input is already
// synchronised to clk; mem_din is stable at the end of a T_READ window.
module pmem_wr_seq
    import pmem_seq_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int T_SETUP     = 2,
    parameter int T_PULSE     = 16,
    parameter int T_HOLD      = 2,
    parameter int T_READ      = 32,
    parameter int T_BUSY_DLY  = 6,
    parameter int T_GAP       = 1,
    parameter int TIMEOUT_CYC = 400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_poll,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic              mem_ready
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int T_MAX_A  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int T_MAX_B  = (T_HOLD > T_READ) ? T_HOLD : T_READ;
    localparam int T_MAX_C  = (T_BUSY_DLY > T_GAP) ? T_BUSY_DLY : T_GAP;
    localparam int T_MAX_AB = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int T_MAX    = (T_MAX_AB > T_MAX_C) ? T_MAX_AB : T_MAX_C;
    localparam int CNT_W    = (T_MAX < 2) ? 1 : $clog2(T_MAX);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(T_READ - 1);
    localparam logic [CNT_W-1:0] LD_BUSY  = CNT_W'(T_BUSY_DLY - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(T_GAP - 1);

    seq_state_e        state, state_nxt;
    strobe_t           pins;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              to_fired, to_run;
    logic              capture, done_ok, done_err, take_rdata;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic              cur_write, cur_poll;
    logic              poll_match;

    pmem_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .addr_i  (req_addr),
        .data_i  (req_wdata),
        .write_i (req_write),
        .poll_i  (mode_poll),
        .addr_o  (cur_addr),
        .data_o  (cur_data),
        .write_o (cur_write),
        .poll_o  (cur_poll)
    );

    pmem_phase_timer #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pmem_poll_timeout #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (capture),
        .run   (to_run),
        .fired (to_fired)
    );

    // Bit-7 comparison that marks the end of a pending store.
    assign poll_match = (mem_din[POLL_BIT] == cur_data[POLL_BIT]);
    assign to_run     = is_wait_state(state) && cur_write;

    // Next state, phase-timer loads and transaction outcome.
    always_comb begin
        state_nxt  = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        capture    = 1'b0;
        done_ok    = 1'b0;
        done_err   = 1'b0;
        take_rdata = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WR_SETUP;
                        tmr_val   = LD_SETUP;
                    end else begin
                        state_nxt = ST_RD_ACC;
                        tmr_val   = LD_READ;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    take_rdata = 1'b1;
                    done_ok    = 1'b1;
                    state_nxt  = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) begin
                    state_nxt = ST_BSY_DLY;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_BUSY;
                end
            end
            ST_BSY_DLY: begin
                if (tmr_expired) begin
                    if (cur_poll) begin
                        state_nxt = ST_POLL_RD;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_READ;
                    end else begin
                        state_nxt = ST_RB_WAIT;
                    end
                end
            end
            ST_RB_WAIT: begin
                if (mem_ready) begin
                    done_ok   = 1'b1;
                    state_nxt = ST_IDLE;
                end
            end
            ST_POLL_RD: begin
                if (tmr_expired) begin
                    if (poll_match) begin
                        done_ok   = 1'b1;
                        state_nxt = ST_IDLE;
                    end else begin
                        state_nxt = ST_POLL_GAP;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_GAP;
                    end
                end
            end
            ST_POLL_GAP: begin
                if (tmr_expired) begin
                    state_nxt = ST_POLL_RD;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_READ;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        // A completion seen in the same cycle wins over the timeout.
        if (to_fired && !done_ok) begin
            done_err  = 1'b1;
            state_nxt = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // One-cycle acknowledge with its error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= done_ok || done_err;
            rsp_err   <= done_err;
        end
    end

    // Read data captured at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (take_rdata)
            rsp_rdata <= mem_din;
    end

    // Pin levels follow the registered state only.
    assign pins        = strobe_for(state);
    assign mem_ce_n    = pins.ce_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_we_n    = pins.we_n;
    assign mem_dout_en = pins.drive;
    assign mem_addr    = cur_addr;
    assign mem_dout    = cur_data;
    assign req_ready   = (state == ST_IDLE);
endmodule

// File: rtl/pmem_wr_seq_chk.sv
// Protocol checker for pmem_wr_seq, attached by bind. It watches only the
// ports of the sequencer.
module pmem_wr_seq_chk #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dout,
    input logic          mem_dout_en,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n
);
    a_r4_we_framed: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    a_r4_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r9_released_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && req_ready));
endmodule

bind pmem_wr_seq pmem_wr_seq_chk #(
    .AW (ADDR_W),
    .DW (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n)
);

// File: tb/test_pmem_wr_seq.sv
// Directed bench for pmem_wr_seq with a behavioural self-timed memory model.
module test_pmem_wr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int P_SETUP = 2;
    localparam int P_PULSE = 3;
    localparam int P_HOLD = 2;
    localparam int P_READ = 4;
    localparam int P_BUSY = 3;
    localparam int P_GAP = 2;
    localparam int P_TO = 150;
    localparam int M_STORE = 40;
    localparam int M_LAG = P_HOLD + P_BUSY - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_poll = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout, mem_din;
    logic mem_dout_en, mem_ce_n, mem_oe_n, mem_we_n, mem_ready;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmem_wr_seq #(
        .ADDR_W (AW), .DATA_W (DW), .T_SETUP (P_SETUP), .T_PULSE (P_PULSE),
        .T_HOLD (P_HOLD), .T_READ (P_READ), .T_BUSY_DLY (P_BUSY),
        .T_GAP (P_GAP), .TIMEOUT_CYC (P_TO)
    ) i_pmem_wr_seq (
        .clk (clk), .rst_n (rst_n), .mode_poll (mode_poll),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_dout (mem_dout), .mem_dout_en (mem_dout_en),
        .mem_din (mem_din), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n), .mem_ready (mem_ready)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory model: 16 bytes, self-timed store, ready low after a lag.
    logic [7:0] mem_m [16];
    int busy_cnt = 0;
    int lag_cnt = 0;
    int oe_cnt = 0;
    bit stuck = 1'b0;
    logic [7:0] pend_d = '0;
    logic [3:0] pend_a = '0;
    // Write-strobe monitor state.
    int phase = 0;
    int setup_cnt = 0;
    int pulse_cnt = 0;
    int hold_cnt = 0;
    int gap_cnt = 0;
    int oe_falls = 0;
    bit gap_chk = 1'b0;
    bit prev_oe = 1'b1;
    logic [AW-1:0] lat_a = '0;
    logic [DW-1:0] lat_d = '0;

    always_comb begin
        mem_ready = !(busy_cnt > 0 && lag_cnt == 0);
        if (busy_cnt > 0)
            mem_din = {~pend_d[7], 7'h2A};
        else if (oe_cnt >= P_READ)
            mem_din = mem_m[mem_addr[3:0]];
        else
            mem_din = ~mem_m[mem_addr[3:0]];
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem_m[i] = 8'(i * 17 + 3);
            busy_cnt = 0; lag_cnt = 0; oe_cnt = 0; phase = 0;
        end else begin
            // store progress
            if (busy_cnt > 0) begin
                if (lag_cnt > 0) lag_cnt--;
                else if (!stuck) begin
                    busy_cnt--;
                    if (busy_cnt == 0) mem_m[pend_a] = pend_d;
                end
            end
            if (!mem_ce_n && !mem_oe_n) oe_cnt++; else oe_cnt = 0;
            // poll read spacing (R8)
            if (!mem_oe_n && prev_oe) begin
                oe_falls++;
                if (gap_chk && oe_falls > 1)
                    check(gap_cnt >= P_GAP, "R8", "oe high gap between polls", gap_cnt, P_GAP);
                gap_cnt = 0;
            end else if (mem_oe_n) gap_cnt++;
            prev_oe = mem_oe_n;
            // write strobe timing (R3, R4, R5)
            if (mem_ce_n) begin
                if (phase == 3)
                    check(hold_cnt >= P_HOLD, "R5", "hold cycles", hold_cnt, P_HOLD);
                phase = 0; setup_cnt = 0;
            end else if (!mem_we_n) begin
                if (phase != 2) begin
                    check(setup_cnt >= P_SETUP && mem_oe_n && mem_dout_en, "R3",
                          "setup cycles", setup_cnt, P_SETUP);
                    phase = 2; pulse_cnt = 1; lat_a = mem_addr; lat_d = mem_dout;
                end else begin
                    pulse_cnt++;
                    check(mem_addr == lat_a && mem_dout == lat_d, "R4",
                          "bus steady in pulse", int'(mem_dout), int'(lat_d));
                end
            end else if (phase == 2) begin
                check(pulse_cnt >= P_PULSE, "R4", "pulse cycles", pulse_cnt, P_PULSE);
                phase = 3; hold_cnt = 1;
                pend_a = lat_a[3:0]; pend_d = lat_d;
                busy_cnt = M_STORE; lag_cnt = M_LAG;
            end else if (phase == 3) begin
                if (mem_dout_en) hold_cnt++;
            end else if (mem_oe_n && mem_dout_en) begin
                setup_cnt++; phase = 1;
            end
        end
    end

    task automatic run_txn(input bit wr, input bit poll, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, output logic [DW-1:0] rd,
                           output bit err, output int lat, output int rdy_seen);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; mode_poll = poll;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; rdy_seen = 0;
        while (!rsp_valid) begin
            if (req_ready) rdy_seen++;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata; err = rsp_err;
        @(negedge clk);
        check(!rsp_valid && !rsp_err, "R10", "ack lasts one cycle", int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        check({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "strobes in reset",
              int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        check(!mem_dout_en && !rsp_valid && req_ready, "R1", "idle outputs in reset",
              int'({mem_dout_en, rsp_valid, req_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, req_ready} == 5'b11101, "R1",
              "first cycle after reset", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, req_ready}), 29);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string why);
        logic [DW-1:0] rd; bit err; int lat, rs;
        run_txn(1'b0, 1'b0, a, '0, rd, err, lat, rs);
        check(rd == exp && !err, "R2", why, int'(rd), int'(exp));
    endtask

    task automatic t_write(input bit poll, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; bit err; int lat, rs;
        oe_falls = 0; gap_chk = poll;
        run_txn(1'b1, poll, a, d, rd, err, lat, rs);
        gap_chk = 1'b0;
        if (poll) begin
            check(!err, "R8", "poll write no error", int'(err), 0);
            check(mem_m[a[3:0]] == d, "R8", "store done at poll ack", int'(mem_m[a[3:0]]), int'(d));
            check(oe_falls >= 2, "R8", "several poll reads", oe_falls, 2);
        end else begin
            check(!err, "R7", "ready write no error", int'(err), 0);
            check(mem_m[a[3:0]] == d, "R6", "store done at ready ack", int'(mem_m[a[3:0]]), int'(d));
        end
        check(rs == 0, "R10", "req_ready low in transaction", rs, 0);
        t_read(a, d, "read back after write");
    endtask

    task automatic t_timeout(input bit poll);
        logic [DW-1:0] rd; bit err; int lat, rs;
        stuck = 1'b1;
        run_txn(1'b1, poll, 13'h5, 8'h81, rd, err, lat, rs);
        check(err, "R9", "timeout error flag", int'(err), 1);
        check(lat >= P_TO, "R9", "timeout latency", lat, P_TO);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en} == 4'b1110, "R9", "released after timeout",
              int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}), 14);
        stuck = 1'b0;
        while (busy_cnt > 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_read(13'h3, 8'(3 * 17 + 3), "preloaded byte 3");
        t_read(13'h1C, 8'(12 * 17 + 3), "preloaded byte 12");
        t_write(1'b0, 13'h2, 8'h3C);
        t_write(1'b0, 13'h9, 8'hB7);
        t_write(1'b1, 13'h4, 8'hC5);
        t_write(1'b1, 13'h7, 8'h17);
        t_timeout(1'b0);
        t_timeout(1'b1);
        t_read(13'h5, 8'h81, "store finished after stuck timeout");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule